// File: doc/BRIEF.md
# PS/2 Mouse Packet Decoder

This block listens passively to a pointing device on the two-wire PS/2 bus. Both the clock line and the data line are driven by the device. The block brings the two lines into the system clock domain and removes short spikes from them. It then collects serial frames and groups the bytes into three-byte movement reports. It never drives the bus and never sends commands to the device.

Each report starts with a status byte that carries the button states, two sign bits and two overflow flags. Movement along X and then along Y follows in the next two bytes. The block joins each sign bit to its movement byte, so the host sees two 9-bit two's-complement deltas. Positive Y means the device moved up, and a larger magnitude means faster motion.

All fields update together and stay stable until the next report. A single-cycle strobe marks each new report. A bad status byte, a damaged frame or a stalled frame returns the block to the status-byte slot, so that report framing does not drift.

Top module: `ps2_mouse_decoder`

## Requirements
- R1: After a synchronous active-low reset, packet_valid, all button outputs, both overflow flags, x_delta and y_delta are 0.
- R2: A frame is 11 bits, each sampled on a falling edge of the filtered PS/2 clock. The bits are: a start bit of 0, then 8 data bits least significant first, then a parity bit that makes the 9 bits data+parity hold an odd number of ones, then a stop bit of 1.
- R3: The first byte of a report is the status byte. Bit 0 is the left button, bit 1 the right button, bit 2 the middle button, bit 3 must be 1, bit 4 is the X sign, bit 5 the Y sign, bit 6 the X overflow and bit 7 the Y overflow. These drive btn_left, btn_right, btn_middle, x_overflow and y_overflow.
- R4: x_delta is {X sign, second byte} and y_delta is {Y sign, third byte}, each read as a 9-bit two's-complement value.
- R5: packet_valid is high for exactly one system clock after the third byte of a report is accepted. All report outputs change only in that cycle.
- R6: A byte received in the status slot with bit 3 equal to 0 is dropped. The next byte is again treated as a status byte.
- R7: A frame with a wrong start bit, a wrong parity bit or a stop bit of 0 is dropped, and the next byte is treated as a status byte.
- R8: If the filtered PS/2 clock shows no falling edge for IDLE_TIMEOUT_US inside a frame, the partial frame is dropped and the next byte is treated as a status byte.
- R9: A level change on either bus line that lasts fewer than FILTER_CYCLES system clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_in | input | 1 | PS/2 clock line, asynchronous |
| ps2_data_in | input | 1 | PS/2 data line, asynchronous |
| packet_valid | output | 1 | One-cycle strobe for a new report |
| btn_left | output | 1 | Left button pressed |
| btn_right | output | 1 | Right button pressed |
| btn_middle | output | 1 | Middle button pressed |
| x_delta | output | 9 | Signed X movement |
| y_delta | output | 9 | Signed Y movement |
| x_overflow | output | 1 | X movement overflowed |
| y_overflow | output | 1 | Y movement overflowed |

## Verification
The bench targets resynchronisation after faults.

- **Bad status byte.** A design that accepts a status byte with bit 3 clear would report a packet built from shifted bytes.
- **Parity or stop error.** A design that keeps its byte position after such an error would take the next status byte as an X byte.
- **Stalled frame.** A design without the idle timeout would merge the stalled frame's bits into the following frame.
- **Clock glitch.** A design without filtering would take a two-cycle clock glitch between frames as a start bit.
- **Sign reconstruction.** Vectors with negative deltas and extreme byte values catch a design that sign-extends the movement byte instead of using the status sign bit.

// File: rtl/ps2m_pkg.sv
// Package ps2m_pkg
// Shared constants and types for the PS/2 mouse decoder.
// Assumes the standard 11-bit device-to-host frame.
package ps2m_pkg;

    localparam int FRAME_BITS = 11;
    localparam int BYTE_W     = 8;
    localparam int DELTA_W    = BYTE_W + 1;

    // Status byte bit positions (decoded by the report assembler)
    localparam int ST_LEFT   = 0;
    localparam int ST_RIGHT  = 1;
    localparam int ST_MIDDLE = 2;
    localparam int ST_ONE    = 3;
    localparam int ST_XSIGN  = 4;
    localparam int ST_YSIGN  = 5;
    localparam int ST_XOVF   = 6;
    localparam int ST_YOVF   = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SLOT_STATUS = 2'd0,
        SLOT_X      = 2'd1,
        SLOT_Y      = 2'd2
    } slot_e;

endpackage

// File: rtl/ps2m_line_filter.sv
// Module ps2m_line_filter
// Brings one asynchronous line into the clk domain through two flops and
// then debounces it. The output follows the input only after the input has
// differed from the output for FILTER_CYCLES consecutive clocks.
// Assumes the line idles high (reset value 1).
module ps2m_line_filter #(
    parameter int FILTER_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(FILTER_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILTER_CYCLES - 1);

    logic       meta_q;
    logic       sync_q;
    logic [CW-1:0] diff_cnt;

    // Two-flop synchroniser for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
        end
    end

    // Count consecutive differing samples and flip the output once enough are seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_cnt <= '0;
            line_out <= 1'b1;
        end else if (sync_q == line_out) begin
            diff_cnt <= '0;
        end else if (diff_cnt == CNT_LAST) begin
            diff_cnt <= '0;
            line_out <= sync_q;
        end else begin
            diff_cnt <= diff_cnt + 1'b1;
        end
    end

    // R9: the filtered level only moves after a run of differing synchronised samples
    a_r9_filtered_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out != $past(line_out)) |-> ($past(sync_q) != $past(line_out)));

endmodule

// File: rtl/ps2m_frame_rx.sv
// Module ps2m_frame_rx
// Shifts in 11-bit PS/2 frames on falling edges of the filtered clock and
// checks start, odd parity and stop. It pulses byte_ok with the data byte or
// byte_err for a bad frame. It also pulses frame_abort when the clock stalls
// inside a frame for TIMEOUT_CYCLES system clocks.
// Assumes clean, already synchronised line levels.
module ps2m_frame_rx
    import ps2m_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 5000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bus_clk,
    input  logic  bus_dat,
    output logic  byte_ok,
    output logic  byte_err,
    output logic  frame_abort,
    output byte_t byte_data
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] IDLE_LAST = TW'(TIMEOUT_CYCLES - 1);
    localparam logic [3:0]    BIT_LAST  = 4'(FRAME_BITS - 1);

    logic                  clk_prev;
    logic                  clk_fall;
    logic [3:0]            bit_cnt;
    logic [FRAME_BITS-2:0] shreg;
    logic [TW-1:0]         idle_cnt;
    logic                  start_ok;
    logic                  parity_ok;

    // Remember the previous clock level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= bus_clk;
    end

    assign clk_fall  = clk_prev & ~bus_clk;
    assign start_ok  = ~shreg[0];
    assign parity_ok = ^shreg[FRAME_BITS-2:1];

    // Frame shifter, checker and stall timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            idle_cnt    <= '0;
            byte_ok     <= 1'b0;
            byte_err    <= 1'b0;
            frame_abort <= 1'b0;
            byte_data   <= '0;
        end else begin
            byte_ok     <= 1'b0;
            byte_err    <= 1'b0;
            frame_abort <= 1'b0;
            if (clk_fall) begin
                idle_cnt <= '0;
                if (bit_cnt == BIT_LAST) begin
                    bit_cnt <= '0;
                    if (start_ok && parity_ok && bus_dat) begin
                        byte_ok   <= 1'b1;
                        byte_data <= shreg[BYTE_W:1];
                    end else begin
                        byte_err  <= 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {bus_dat, shreg[FRAME_BITS-2:1]};
                end
            end else if (bit_cnt != '0) begin
                if (idle_cnt == IDLE_LAST) begin
                    frame_abort <= 1'b1;
                    bit_cnt     <= '0;
                    idle_cnt    <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end else begin
                idle_cnt <= '0;
            end
        end
    end

    // R2: a frame ends either good or bad, never both
    a_r2_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_ok && byte_err));

    // R8: an abort leaves the receiver waiting for a new start bit
    a_r8_abort_clears_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |-> (bit_cnt == '0));

    // R8: no stall abort while no frame is in progress
    a_r8_no_abort_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == '0 && !clk_fall) |=> !frame_abort);

endmodule

// File: rtl/ps2m_packet_asm.sv
// Module ps2m_packet_asm
// Groups accepted bytes into status/X/Y reports, rebuilds the signed deltas
// and holds the outputs between reports. Any frame fault or a status byte
// without its always-one bit sends it back to the status slot.
// Assumes byte_ok, byte_err and frame_abort are single-cycle and exclusive.
module ps2m_packet_asm
    import ps2m_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_ok,
    input  logic               byte_err,
    input  logic               frame_abort,
    input  byte_t              byte_data,
    output logic               packet_valid,
    output logic               btn_left,
    output logic               btn_right,
    output logic               btn_middle,
    output logic [DELTA_W-1:0] x_delta,
    output logic [DELTA_W-1:0] y_delta,
    output logic               x_overflow,
    output logic               y_overflow
);
    slot_e slot;
    byte_t status_q;
    byte_t x_q;

    // Report slot sequencing, byte capture and output update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot         <= SLOT_STATUS;
            status_q     <= '0;
            x_q          <= '0;
            packet_valid <= 1'b0;
            btn_left     <= 1'b0;
            btn_right    <= 1'b0;
            btn_middle   <= 1'b0;
            x_delta      <= '0;
            y_delta      <= '0;
            x_overflow   <= 1'b0;
            y_overflow   <= 1'b0;
        end else begin
            packet_valid <= 1'b0;
            if (byte_err || frame_abort) begin
                slot <= SLOT_STATUS;
            end else if (byte_ok) begin
                unique case (slot)
                    SLOT_STATUS: begin
                        if (byte_data[ST_ONE]) begin
                            status_q <= byte_data;
                            slot     <= SLOT_X;
                        end
                    end
                    SLOT_X: begin
                        x_q  <= byte_data;
                        slot <= SLOT_Y;
                    end
                    SLOT_Y: begin
                        packet_valid <= 1'b1;
                        btn_left     <= status_q[ST_LEFT];
                        btn_right    <= status_q[ST_RIGHT];
                        btn_middle   <= status_q[ST_MIDDLE];
                        x_overflow   <= status_q[ST_XOVF];
                        y_overflow   <= status_q[ST_YOVF];
                        x_delta      <= {status_q[ST_XSIGN], x_q};
                        y_delta      <= {status_q[ST_YSIGN], byte_data};
                        slot         <= SLOT_STATUS;
                    end
                    default: slot <= SLOT_STATUS;
                endcase
            end
        end
    end

    // R5: the report strobe never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        packet_valid |=> !packet_valid);

    // R5: a report only follows a byte accepted in the Y slot
    a_r5_valid_after_y: assert property (@(posedge clk) disable iff (!rst_n)
        packet_valid |-> ($past(slot) == SLOT_Y && $past(byte_ok)));

    // R5: report outputs hold between strobes
    a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !packet_valid |=> (packet_valid || $stable(x_delta)));

    // R6: a status byte lacking its always-one bit is dropped
    a_r6_bad_status_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && slot == SLOT_STATUS && !byte_data[ST_ONE]) |=>
        (slot == SLOT_STATUS && !packet_valid));

    // R7 and R8: any frame fault restarts report framing
    a_r7_fault_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_err || frame_abort) |=> (slot == SLOT_STATUS));

endmodule

// File: rtl/ps2_mouse_decoder.sv
// Module ps2_mouse_decoder
// Top level: line filters for both PS/2 wires, the frame receiver and the
// report assembler. Receive only; the bus is never driven.
// Assumes CLK_FREQ_HZ is a multiple of 1 MHz.
module ps2_mouse_decoder
    import ps2m_pkg::*;
#(
    parameter int CLK_FREQ_HZ     = 50_000_000,
    parameter int IDLE_TIMEOUT_US = 100,
    parameter int FILTER_CYCLES   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ps2_clk_in,
    input  logic               ps2_data_in,
    output logic               packet_valid,
    output logic               btn_left,
    output logic               btn_right,
    output logic               btn_middle,
    output logic [DELTA_W-1:0] x_delta,
    output logic [DELTA_W-1:0] y_delta,
    output logic               x_overflow,
    output logic               y_overflow
);
    localparam int CYC_PER_US     = CLK_FREQ_HZ / 1_000_000;
    localparam int TIMEOUT_CYCLES = CYC_PER_US * IDLE_TIMEOUT_US;
    localparam int N_LINES        = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic               rx_ok;
    logic               rx_err;
    logic               rx_abort;
    byte_t              rx_byte;

    assign raw_lines = {ps2_data_in, ps2_clk_in};

    // One filter per bus wire (index 0 clock, index 1 data)
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        ps2m_line_filter #(
            .FILTER_CYCLES(FILTER_CYCLES)
        ) i_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw_lines[g]),
            .line_out(clean_lines[g])
        );
    end

    ps2m_frame_rx #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) i_frame_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_clk    (clean_lines[0]),
        .bus_dat    (clean_lines[1]),
        .byte_ok    (rx_ok),
        .byte_err   (rx_err),
        .frame_abort(rx_abort),
        .byte_data  (rx_byte)
    );

    ps2m_packet_asm i_packet_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_ok     (rx_ok),
        .byte_err    (rx_err),
        .frame_abort (rx_abort),
        .byte_data   (rx_byte),
        .packet_valid(packet_valid),
        .btn_left    (btn_left),
        .btn_right   (btn_right),
        .btn_middle  (btn_middle),
        .x_delta     (x_delta),
        .y_delta     (y_delta),
        .x_overflow  (x_overflow),
        .y_overflow  (y_overflow)
    );

    // R4: the delta sign bits come from the status byte, so each must match the stored report
    a_r4_sign_from_status: assert property (@(posedge clk) disable iff (!rst_n)
        packet_valid |-> (x_delta[DELTA_W-1] == $past(i_packet_asm.status_q[ST_XSIGN])));

endmodule

// File: tb/test_ps2_mouse_decoder.sv
// Bench for ps2_mouse_decoder: a vector table of reports, then directed tests.
module test_ps2_mouse_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       packet_valid;
    logic       btn_left, btn_right, btn_middle;
    logic [8:0] x_delta, y_delta;
    logic       x_overflow, y_overflow;

    int checks = 0;
    int errors = 0;
    int pkt_cnt = 0;
    int double_strobe = 0;
    logic prev_valid = 1'b0;
    logic finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ps2_mouse_decoder #(
        .CLK_FREQ_HZ(50_000_000),
        .IDLE_TIMEOUT_US(2),
        .FILTER_CYCLES(4)
    ) i_ps2_mouse_decoder (
        .clk(clk), .rst_n(rst_n),
        .ps2_clk_in(ps2_clk), .ps2_data_in(ps2_dat),
        .packet_valid(packet_valid),
        .btn_left(btn_left), .btn_right(btn_right), .btn_middle(btn_middle),
        .x_delta(x_delta), .y_delta(y_delta),
        .x_overflow(x_overflow), .y_overflow(y_overflow)
    );

    // Report strobe monitor (R5)
    always @(negedge clk) begin
        if (packet_valid) pkt_cnt++;
        if (packet_valid && prev_valid) double_strobe++;
        prev_valid = packet_valid;
    end

    localparam logic [23:0] VECS [6] = '{
        24'h08_00_00, 24'h09_05_0A, 24'h1A_FB_03,
        24'h2C_10_F0, 24'hFF_FF_FF, 24'h4B_80_7F
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send the first nbits of a frame; bad_par/bad_stop corrupt the frame
    task automatic send_bits(input logic [7:0] b, input logic bad_par,
                             input logic bad_stop, input int nbits);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            ps2_dat = f[i];
            wait_cyc(10);
            ps2_clk = 1'b0;
            wait_cyc(20);
            ps2_clk = 1'b1;
            wait_cyc(10);
        end
        ps2_dat = 1'b1;
        wait_cyc(30);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 1'b0, 1'b0, 11);
    endtask

    task automatic send_report(input logic [23:0] r);
        send_byte(r[23:16]);
        send_byte(r[15:8]);
        send_byte(r[7:0]);
    endtask

    // Compare outputs with a report derived from R3/R4
    task automatic check_report(input string req, input logic [23:0] r);
        logic [7:0] s;
        s = r[23:16];
        check({req, " R3 buttons"}, {btn_middle, btn_right, btn_left}, s[2:0]);
        check({req, " R3 overflow"}, {y_overflow, x_overflow}, s[7:6]);
        check({req, " R4 x_delta"}, x_delta, {s[4], r[15:8]});
        check({req, " R4 y_delta"}, y_delta, {s[5], r[7:0]});
    endtask

    initial begin
        int base;
        wait_cyc(5);
        // R1: reset state
        check("R1 valid", packet_valid, 0);
        check("R1 outputs", {btn_left, btn_right, btn_middle, x_overflow, y_overflow, x_delta, y_delta}, 0);
        rst_n = 1'b1;
        wait_cyc(10);

        // R2 R3 R4 R5: table of reports
        foreach (VECS[k]) begin
            base = pkt_cnt;
            send_report(VECS[k]);
            check("R5 one report per three bytes", pkt_cnt - base, 1);
            check_report("R2 table", VECS[k]);
        end

        // R6: status byte with bit 3 clear is dropped, then a good report
        base = pkt_cnt;
        send_byte(8'h01);
        send_report(24'h19_22_33);
        check("R6 report count", pkt_cnt - base, 1);
        check_report("R6", 24'h19_22_33);

        // R7: parity error mid-report restarts framing
        base = pkt_cnt;
        send_byte(8'h0A);
        send_bits(8'h44, 1'b1, 1'b0, 11);
        send_report(24'h2A_81_01);
        check("R7 parity report count", pkt_cnt - base, 1);
        check_report("R7 parity", 24'h2A_81_01);

        // R7: stop-bit error mid-report restarts framing
        base = pkt_cnt;
        send_byte(8'h09);
        send_byte(8'h11);
        send_bits(8'h22, 1'b0, 1'b1, 11);
        send_report(24'h0C_07_09);
        check("R7 stop report count", pkt_cnt - base, 1);
        check_report("R7 stop", 24'h0C_07_09);

        // R8: stalled partial frame is dropped
        base = pkt_cnt;
        send_byte(8'h0B);
        send_bits(8'h55, 1'b0, 1'b0, 5);
        wait_cyc(300);
        send_report(24'h3B_FE_FD);
        check("R8 stall report count", pkt_cnt - base, 1);
        check_report("R8", 24'h3B_FE_FD);

        // R9: two-cycle clock glitch between frames is ignored
        base = pkt_cnt;
        send_byte(8'h1C);
        ps2_clk = 1'b0;
        wait_cyc(2);
        ps2_clk = 1'b1;
        wait_cyc(20);
        send_byte(8'hF0);
        send_byte(8'h0F);
        check("R9 glitch report count", pkt_cnt - base, 1);
        check_report("R9", 24'h1C_F0_0F);

        // R5: outputs hold after the strobe with no new traffic
        wait_cyc(200);
        check("R5 hold", pkt_cnt - base, 1);
        check_report("R5 hold", 24'h1C_F0_0F);
        check("R5 strobe width", double_strobe, 0);

        // R1: reset clears a loaded report
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1 re-reset", {btn_left, btn_middle, x_delta, y_delta}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule